// File: doc/BRIEF.md
# Polled Status Register Responder

This block sits behind the bit-level front end of a single-wire serial memory slave. The front end hands it whole bytes from the master with a strobe. It also reports each acknowledge slot as an event: a master acknowledge (continue) or a master no-acknowledge (stop). The block checks the start header, the device address and the command byte of each transaction. It keeps the write-enable latch and the two block-protect bits, and it reads a live busy flag from the write engine.

On a read-status command the block offers the status byte to the front end through a valid/ready handshake. After each byte a continue acknowledge makes it offer the byte again with no new command. A stop acknowledge returns it to idle. The busy and latch bits are taken live for every byte offered, so a master can poll the byte until a write finishes.

Top module: `sps_status_responder`

## Requirements
- R1: After reset `tx_valid` is 0, the write-enable latch is 0 and both protect bits are 0, so a first status read returns 0x00.
- R2: The status byte holds WIP in bit 0, the write-enable latch in bit 1, protect bit 0 in bit 2 and protect bit 1 in bit 3. Bits 7..4 are always 0.
- R3: A transaction needs the header byte 0x55, then the device byte 0xA0, then a command byte. Any other byte where a header or device byte is expected sends the block back to idle, and it gives no response.
- R4: The command 0x05 raises `tx_valid` on the cycle after the command byte is strobed. `tx_valid` stays high until a cycle in which `tx_ready` is 1.
- R5: After a byte is accepted, `tx_valid` stays low until an acknowledge event arrives. A continue acknowledge (`ack_mak`=1) raises `tx_valid` again on the next cycle. A stop acknowledge (`ack_mak`=0) returns the block to idle with `tx_valid` low.
- R6: While `tx_valid` is high, bit 0 of `tx_byte` follows `busy` in the same cycle. Each repeated byte carries the current WIP and latch values.
- R7: Command 0x96 sets the write-enable latch and command 0x91 clears it. Neither produces a response.
- R8: Command 0x6E followed by one data byte loads protect bit 1 from data bit 3 and protect bit 0 from data bit 2. Any status read that starts afterwards returns the new values, even while `busy` is 1.
- R9: A one-cycle `wr_done` pulse clears the write-enable latch, unless a 0x96 command is taken in the same cycle.
- R10: An unknown command byte gives no response and leaves the latch and protect bits unchanged.
- R11: Acknowledge events outside the slot that follows a sent byte are ignored, and `tx_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Strobe for a received byte |
| rx_byte | input | 8 | Received byte from the front end |
| ack_valid | input | 1 | Strobe for an acknowledge event from the master |
| ack_mak | input | 1 | 1 = continue acknowledge, 0 = stop acknowledge |
| busy | input | 1 | Write engine is running a write |
| wr_done | input | 1 | One-cycle pulse at the end of a write |
| tx_ready | input | 1 | Front end takes the offered byte |
| tx_valid | output | 1 | A status byte is offered |
| tx_byte | output | 8 | Status byte; 0 while `tx_valid` is low |

## Verification
The bench checks that a polled byte follows `busy` while it waits for `tx_ready`, and again between repeated bytes. A design that latched the status at command time would keep showing a write in progress after it had finished. It checks that a stop acknowledge silences the block and that a later stray continue acknowledge brings no byte back; a design that only paused would start sending again. A header one bit off, and a wrong device byte, must give no response; a lax compare would answer them. Protect values written while `busy` is high must appear on the next read, and a write-done pulse must drop the latch that a 0x96 command set.

// File: rtl/sps_pkg.sv
package sps_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_ADDR    = 3'd1,
    ST_CMD     = 3'd2,
    ST_DATA    = 3'd3,
    ST_SEND    = 3'd4,
    ST_WAITACK = 3'd5
  } sps_state_e;

  // field order matches the status byte, lsb first: wip, wel, bp0, bp1
  typedef struct packed {
    logic bp1;
    logic bp0;
    logic wel;
    logic wip;
  } sps_status_t;

  localparam int STAT_W = $bits(sps_status_t);

  function automatic logic [BYTE_W-1:0] sps_pack(input sps_status_t s);
    logic [BYTE_W-1:0] b;
    b = '0;
    b[STAT_W-1:0] = s;
    return b;
  endfunction

endpackage

// File: rtl/sps_rst_sync.sv
module sps_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/sps_seq.sv
module sps_seq
  import sps_pkg::*;
#(
  parameter logic [BYTE_W-1:0] HDR_BYTE = 8'h55,
  parameter logic [BYTE_W-1:0] DEV_BYTE = 8'hA0,
  parameter logic [BYTE_W-1:0] OP_READ  = 8'h05,
  parameter logic [BYTE_W-1:0] OP_WEN   = 8'h96,
  parameter logic [BYTE_W-1:0] OP_WDIS  = 8'h91,
  parameter logic [BYTE_W-1:0] OP_WSTAT = 8'h6E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              ack_valid,
  input  logic              ack_mak,
  input  logic              tx_ready,
  output sps_state_e        state,
  output logic              tx_valid,
  output logic              wen_hit,
  output logic              wdis_hit,
  output logic              wst_load
);

  sps_state_e state_d;
  logic       state_en;

  always_comb begin
    state_d  = state;
    wen_hit  = 1'b0;
    wdis_hit = 1'b0;
    wst_load = 1'b0;
    case (state)
      ST_IDLE: begin
        if (rx_valid && rx_byte == HDR_BYTE) state_d = ST_ADDR;
      end
      ST_ADDR: begin
        if (rx_valid) state_d = (rx_byte == DEV_BYTE) ? ST_CMD : ST_IDLE;
      end
      ST_CMD: begin
        if (rx_valid) begin
          state_d = ST_IDLE;
          if (rx_byte == OP_READ)       state_d  = ST_SEND;
          else if (rx_byte == OP_WSTAT) state_d  = ST_DATA;
          else if (rx_byte == OP_WEN)   wen_hit  = 1'b1;
          else if (rx_byte == OP_WDIS)  wdis_hit = 1'b1;
        end
      end
      ST_DATA: begin
        if (rx_valid) begin
          wst_load = 1'b1;
          state_d  = ST_IDLE;
        end
      end
      ST_SEND: begin
        if (tx_ready) state_d = ST_WAITACK;
      end
      ST_WAITACK: begin
        if (ack_valid) state_d = ack_mak ? ST_SEND : ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign state_en = (state_d != state);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state <= ST_IDLE;
    else if (state_en) state <= state_d;
  end

  assign tx_valid = (state == ST_SEND);

endmodule

// File: rtl/sps_regs.sv
module sps_regs
  import sps_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wen_hit,
  input  logic       wdis_hit,
  input  logic       wr_done,
  input  logic       wst_load,
  input  logic [1:0] wst_bp,
  output logic       wel,
  output logic [1:0] bp
);

  logic       wel_d;
  logic       wel_en;
  logic [1:0] bp_d;
  logic       bp_en;

  always_comb begin
    wel_d  = wel;
    if (wen_hit)                  wel_d = 1'b1;
    else if (wdis_hit || wr_done) wel_d = 1'b0;
    wel_en = (wel_d != wel);
    bp_d   = wst_bp;
    bp_en  = wst_load;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wel <= 1'b0;
    else if (wel_en) wel <= wel_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     bp <= '0;
    else if (bp_en) bp <= bp_d;
  end

endmodule

// File: rtl/sps_txsel.sv
module sps_txsel
  import sps_pkg::*;
(
  input  logic              valid,
  input  sps_status_t       status,
  output logic [BYTE_W-1:0] byte_o
);

  always_comb begin
    byte_o = '0;
    if (valid) byte_o = sps_pack(status);
  end

endmodule

// File: rtl/sps_status_responder.sv
module sps_status_responder
  import sps_pkg::*;
#(
  parameter logic [7:0] HDR_BYTE  = 8'h55,
  parameter logic [7:0] DEV_BYTE  = 8'hA0,
  parameter logic [7:0] OP_READ   = 8'h05,
  parameter logic [7:0] OP_WEN    = 8'h96,
  parameter logic [7:0] OP_WDIS   = 8'h91,
  parameter logic [7:0] OP_WSTAT  = 8'h6E,
  parameter int         BP_LSB    = 2,
  parameter int         SYNC_STGS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  input  logic       ack_valid,
  input  logic       ack_mak,
  input  logic       busy,
  input  logic       wr_done,
  input  logic       tx_ready,
  output logic       tx_valid,
  output logic [7:0] tx_byte
);

  logic        srst_n;
  sps_state_e  state;
  logic        wen_hit;
  logic        wdis_hit;
  logic        wst_load;
  logic        wel;
  logic [1:0]  bp;
  sps_status_t status;

  sps_rst_sync #(.STAGES(SYNC_STGS)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  sps_seq #(
    .HDR_BYTE (HDR_BYTE),
    .DEV_BYTE (DEV_BYTE),
    .OP_READ  (OP_READ),
    .OP_WEN   (OP_WEN),
    .OP_WDIS  (OP_WDIS),
    .OP_WSTAT (OP_WSTAT)
  ) u_seq (
    .clk       (clk),
    .rst_n     (srst_n),
    .rx_valid  (rx_valid),
    .rx_byte   (rx_byte),
    .ack_valid (ack_valid),
    .ack_mak   (ack_mak),
    .tx_ready  (tx_ready),
    .state     (state),
    .tx_valid  (tx_valid),
    .wen_hit   (wen_hit),
    .wdis_hit  (wdis_hit),
    .wst_load  (wst_load)
  );

  sps_regs u_regs (
    .clk      (clk),
    .rst_n    (srst_n),
    .wen_hit  (wen_hit),
    .wdis_hit (wdis_hit),
    .wr_done  (wr_done),
    .wst_load (wst_load),
    .wst_bp   (rx_byte[BP_LSB +: 2]),
    .wel      (wel),
    .bp       (bp)
  );

  // live sampling: busy and latch are taken in the cycle the byte is offered
  assign status = '{bp1: bp[1], bp0: bp[0], wel: wel, wip: busy};

  sps_txsel u_tx (
    .valid  (tx_valid),
    .status (status),
    .byte_o (tx_byte)
  );

endmodule

// File: rtl/sps_status_chk.sv
module sps_status_chk
  import sps_pkg::*;
#(
  parameter logic [7:0] DEV_BYTE = 8'hA0
) (
  input logic       clk,
  input logic       srst_n,
  input sps_state_e state,
  input logic       rx_valid,
  input logic [7:0] rx_byte,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [7:0] tx_byte,
  input logic       wr_done,
  input logic       wen_hit,
  input logic       wel
);

  // R2
  hi_nibble_zero_chk: assert property (@(posedge clk) disable iff (!srst_n)
    tx_valid |-> tx_byte[7:4] == 4'h0);

  // R3
  bad_dev_idle_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (state == ST_ADDR && rx_valid && rx_byte != DEV_BYTE) |=> state == ST_IDLE);

  // R4
  hold_offer_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (tx_valid && !tx_ready) |=> tx_valid);

  // R5
  wait_after_send_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (tx_valid && tx_ready) |=> !tx_valid);

  // R9
  done_clears_wel_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (wr_done && !wen_hit) |=> !wel);

  // R11
  idle_silent_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (state == ST_IDLE) |=> !tx_valid);

endmodule

bind sps_status_responder sps_status_chk #(.DEV_BYTE(DEV_BYTE)) u_chk (
  .clk      (clk),
  .srst_n   (srst_n),
  .state    (state),
  .rx_valid (rx_valid),
  .rx_byte  (rx_byte),
  .tx_valid (tx_valid),
  .tx_ready (tx_ready),
  .tx_byte  (tx_byte),
  .wr_done  (wr_done),
  .wen_hit  (wen_hit),
  .wel      (wel)
);

// File: tb/sps_status_responder_test.sv
`timescale 1ns/1ps
module sps_status_responder_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic       ack_valid = 1'b0;
  logic       ack_mak = 1'b0;
  logic       busy = 1'b0;
  logic       wr_done = 1'b0;
  logic       tx_ready = 1'b0;
  logic       tx_valid;
  logic [7:0] tx_byte;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  sps_status_responder uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_valid  (rx_valid),
    .rx_byte   (rx_byte),
    .ack_valid (ack_valid),
    .ack_mak   (ack_mak),
    .busy      (busy),
    .wr_done   (wr_done),
    .tx_ready  (tx_ready),
    .tx_valid  (tx_valid),
    .tx_byte   (tx_byte)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 20000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // {opcode, data, 7'b0, busy, expected status}
  localparam logic [31:0] VEC [8] = '{
    {8'h96, 8'h00, 7'd0, 1'b0, 8'h02},
    {8'h6E, 8'h0C, 7'd0, 1'b1, 8'h0F},
    {8'h91, 8'h00, 7'd0, 1'b0, 8'h0C},
    {8'h33, 8'h00, 7'd0, 1'b0, 8'h0C},
    {8'h6E, 8'hF4, 7'd0, 1'b0, 8'h04},
    {8'h96, 8'h00, 7'd0, 1'b1, 8'h07},
    {8'h6E, 8'h08, 7'd0, 1'b0, 8'h0A},
    {8'h91, 8'h00, 7'd0, 1'b1, 8'h09}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    rx_byte  = b;
    rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic accept();
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
  endtask

  task automatic ack(input logic mak);
    ack_valid = 1'b1;
    ack_mak   = mak;
    @(negedge clk);
    ack_valid = 1'b0;
  endtask

  task automatic start_read();
    send(8'h55);
    send(8'hA0);
    send(8'h05);
  endtask

  // one full read: offer, accept, stop; checks the byte
  task automatic read_once(input string tag, input logic [7:0] exp);
    start_read();
    check({tag, " R4 valid"}, {7'd0, tx_valid}, 8'h01);
    check(tag, tx_byte, exp);
    accept();
    ack(1'b0);
    check({tag, " R5 end"}, {7'd0, tx_valid}, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 tx_valid", {7'd0, tx_valid}, 8'h00);
    check("R1 tx_byte", tx_byte, 8'h00);
    read_once("R1 first read", 8'h00);

    // vector table: R2 R7 R8 R10
    for (int i = 0; i < 8; i++) begin
      busy = VEC[i][8];
      send(8'h55);
      send(8'hA0);
      send(VEC[i][31:24]);
      if (VEC[i][31:24] == 8'h6E) send(VEC[i][23:16]);
      check("R10 R7 no response", {7'd0, tx_valid}, 8'h00);
      read_once("R2 R7 R8 vector", VEC[i][7:0]);
    end
    busy = 1'b0;  // state now: wel=0, bp=10

    // R3 header off by one bit
    send(8'h54); send(8'hA0); send(8'h05);
    check("R3 bad header", {7'd0, tx_valid}, 8'h00);
    // R3 wrong device byte
    send(8'h55); send(8'hA2); send(8'h05);
    check("R3 bad device", {7'd0, tx_valid}, 8'h00);
    @(negedge clk);
    check("R3 still silent", {7'd0, tx_valid}, 8'h00);

    // R6 live polling
    start_read();
    check("R6 first byte", tx_byte, 8'h08);
    busy = 1'b1;
    #1;
    check("R6 live while waiting", tx_byte, 8'h09);
    @(negedge clk);
    check("R4 held without ready", {7'd0, tx_valid}, 8'h01);
    accept();
    check("R5 waits for ack", {7'd0, tx_valid}, 8'h00);
    busy = 1'b0;
    ack(1'b1);
    check("R5 repeat offered", {7'd0, tx_valid}, 8'h01);
    check("R6 repeat is fresh", tx_byte, 8'h08);
    accept();
    ack(1'b0);
    repeat (2) @(negedge clk);
    check("R5 stop stays idle", {7'd0, tx_valid}, 8'h00);

    // R11 stray continue ack in idle
    ack(1'b1);
    @(negedge clk);
    check("R11 ack ignored", {7'd0, tx_valid}, 8'h00);

    // R9 write-done clears latch
    send(8'h55); send(8'hA0); send(8'h96);
    read_once("R9 latch set", 8'h0A);
    wr_done = 1'b1;
    @(negedge clk);
    wr_done = 1'b0;
    read_once("R9 latch cleared", 8'h08);

    // R8 protect write during busy shows on the next read
    busy = 1'b1;
    send(8'h55); send(8'hA0); send(8'h6E); send(8'h04);
    read_once("R8 during busy", 8'h05);
    busy = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule